// File: doc/BRIEF.md
# Per-Channel Soft Reset Controller

This block is the control-register slice of a four-channel serial link conditioner. Each channel keeps its own small bank of registers. A simple write bus selects a channel with `bus_ch`, selects one of that channel's registers with `bus_addr`, and stores `bus_wdata` on a cycle where `bus_we` is high. `bus_rdata` always shows the register that `bus_ch` and `bus_addr` point at.

There are two separate ways to reset a channel. A full register restore is requested by writing a one to bit 2 of register 0x0. On the next clock edge, every register of that channel returns to its default value. That request bit is itself zero in the default, so it clears itself. A one-cycle restore pulse marks the event. The second way is a CDR-only reset, which is driven from register 0xA. Bit 3 of that register arms an override and bit 2 forces the reset. The per-channel `cdr_rst` output is high only while both bits hold one. Register contents never change because of this CDR-only reset.

Top module: `srst_ctrl`

## Requirements
- R1: After reset, every register of every channel holds its default value. The default of address a is ((a*29) mod 256) XOR 0xA5, except that bit 2 is forced to 0 at address 0x0 and bits 3:2 are forced to 0 at address 0xA. After reset, `restore_pulse` and `cdr_rst` are all zero.
- R2: A write with `bus_we` high stores `bus_wdata` into register `bus_addr` of channel `bus_ch` only. Registers of all other channels keep their values.
- R3: A write to address 0x0 of channel c with bit 2 of the data set reloads every register of channel c with its default on the next clock edge. The rest of the write data is discarded. A read of address 0x0 on the following cycle returns bit 2 as 0.
- R4: Such a full-restore write raises `restore_pulse[c]` for exactly the one cycle after the write. No other channel's pulse bit rises.
- R5: `cdr_rst[c]` is high exactly when bit 3 (override enable) and bit 2 (force) of register 0xA of channel c are both 1. Both bits may be set in one write.
- R6: With only one of the two bits of register 0xA set, `cdr_rst[c]` stays low. Clearing bit 2 releases the CDR reset on the next cycle.
- R7: Setting or clearing the CDR-only reset leaves every other register of the channel unchanged.
- R8: A full restore clears both override bits, so any CDR reset on that channel is released in the same cycle as its restore pulse.
- R9: `bus_rdata` shows, with no clock delay, register `bus_addr` of channel `bus_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_ch | input | CH_W (2) | Channel select |
| bus_addr | input | ADDR_W (4) | Register address within the channel |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data of the selected register |
| restore_pulse | output | NCH (4) | One-cycle per-channel full-restore strobe |
| cdr_rst | output | NCH (4) | Per-channel CDR reset level |

## Verification
Directed sequences step the override register of one channel through four patterns: force without enable, enable without force, both set, and force cleared. This separates a reset gated by both bits from one that follows a single bit. Each step is followed by a sweep of the channel's other registers, which shows that the CDR-only path leaves them alone. A full restore issued while a CDR reset is active shows that the override is released and that the request bit reads back as zero. Random writes then mix all channels, with extra weight on the two control addresses. Periodic sweeps of all channels catch writes that reach the wrong channel and restores that reach too far.

// File: rtl/srst_pkg.sv
package srst_pkg;
  localparam int NCH_D    = 4;
  localparam int ADDR_W_D = 4;
  localparam int DATA_W_D = 8;

  localparam int REG_CTRL      = 0;   // full restore request lives here
  localparam int REG_OVR       = 10;  // CDR override pair lives here
  localparam int FULL_BIT      = 2;
  localparam int OVR_EN_BIT    = 3;
  localparam int OVR_FORCE_BIT = 2;

  // Default contents of a register, as a function of its address.
  function automatic logic [31:0] reg_default(input int a);
    logic [31:0] v;
    v = ((a * 29) ^ 32'hA5) & 32'hFF;
    if (a == REG_CTRL) v[FULL_BIT] = 1'b0;
    if (a == REG_OVR) begin
      v[OVR_EN_BIT]    = 1'b0;
      v[OVR_FORCE_BIT] = 1'b0;
    end
    return v;
  endfunction
endpackage

// File: rtl/srst_wr_decode.sv
module srst_wr_decode #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            we,
  input  logic [CH_W-1:0] ch,
  output logic [NCH-1:0]  wr_sel
);
  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign wr_sel[c] = we && (ch == CH_W'(c));
  end
endmodule

// File: rtl/srst_chan_slice.sv
module srst_chan_slice
  import srst_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              full_hit,
  output logic              restore_o,
  output logic              ovr_en,
  output logic              ovr_force,
  output logic              cdr_rst_o
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NREG];
  logic              restore_q;

  function automatic logic [DATA_W-1:0] dflt(input int i);
    logic [31:0] t;
    t = reg_default(i);
    return t[DATA_W-1:0];
  endfunction

  assign full_hit = wr_en && (wr_addr == ADDR_W'(REG_CTRL)) && wr_data[FULL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
    end else if (full_hit) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restore_q <= 1'b0;
    else        restore_q <= full_hit;
  end

  assign rd_data   = regs[rd_addr];
  assign restore_o = restore_q;
  assign ovr_en    = regs[REG_OVR][OVR_EN_BIT];
  assign ovr_force = regs[REG_OVR][OVR_FORCE_BIT];
  assign cdr_rst_o = ovr_en & ovr_force;
endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
  import srst_pkg::*;
#(
  parameter int NCH    = NCH_D,
  parameter int ADDR_W = ADDR_W_D,
  parameter int DATA_W = DATA_W_D,
  parameter int CH_W   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [CH_W-1:0]   bus_ch,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    restore_pulse,
  output logic [NCH-1:0]    cdr_rst
);
  logic [NCH-1:0]    wr_sel;
  logic [NCH-1:0]    full_hit;
  logic [NCH-1:0]    ovr_en;
  logic [NCH-1:0]    ovr_force;
  logic [DATA_W-1:0] ch_rd [NCH];

  srst_wr_decode #(.NCH(NCH), .CH_W(CH_W)) u_dec (
    .we     (bus_we),
    .ch     (bus_ch),
    .wr_sel (wr_sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    srst_chan_slice #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_sel[c]),
      .wr_addr   (bus_addr),
      .wr_data   (bus_wdata),
      .rd_addr   (bus_addr),
      .rd_data   (ch_rd[c]),
      .full_hit  (full_hit[c]),
      .restore_o (restore_pulse[c]),
      .ovr_en    (ovr_en[c]),
      .ovr_force (ovr_force[c]),
      .cdr_rst_o (cdr_rst[c])
    );
  end

  assign bus_rdata = ch_rd[bus_ch];
endmodule

// File: rtl/srst_ctrl_chk.sv
module srst_ctrl_chk
  import srst_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [CH_W-1:0]   bus_ch,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NCH-1:0]    restore_pulse,
  input logic [NCH-1:0]    cdr_rst,
  input logic [NCH-1:0]    full_hit
);
  a_r4_pulse_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (|full_hit) |=> (restore_pulse == $past(full_hit)));

  a_r4_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(restore_pulse));

  a_r8_override_released: assert property (@(posedge clk) disable iff (!rst_n)
    (|restore_pulse) |-> ((cdr_rst & restore_pulse) == '0));

  a_r3_request_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_pulse[bus_ch] && bus_addr == ADDR_W'(REG_CTRL)) |-> !bus_rdata[FULL_BIT]);

  a_r5_rise_needs_both_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cdr_rst & ~$past(cdr_rst))) |->
      $past(bus_we && bus_addr == ADDR_W'(REG_OVR)
            && bus_wdata[OVR_EN_BIT] && bus_wdata[OVR_FORCE_BIT]));

  a_r6_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~cdr_rst & $past(cdr_rst))) |->
      $past(bus_we && (bus_addr == ADDR_W'(REG_OVR)
            || (bus_addr == ADDR_W'(REG_CTRL) && bus_wdata[FULL_BIT]))));
endmodule

bind srst_ctrl srst_ctrl_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_we        (bus_we),
  .bus_ch        (bus_ch),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .restore_pulse (restore_pulse),
  .cdr_rst       (cdr_rst),
  .full_hit      (full_hit)
);

// File: tb/sim_srst_ctrl.sv
`timescale 1ns/1ps
module sim_srst_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_ch = '0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] restore_pulse;
  logic [3:0] cdr_rst;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl [4][16];
  logic [3:0] exp_pulse = '0;

  always #10 clk = ~clk;

  srst_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_ch(bus_ch),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .restore_pulse(restore_pulse), .cdr_rst(cdr_rst)
  );

  // Bench-side default: low byte of 29*a, flipped by 0xA5, with control bits cleared.
  function automatic logic [7:0] exp_default(input int a);
    int v;
    v = ((a * 29) % 256) ^ 165;
    if (a == 0)  v = v & 8'b1111_1011;
    if (a == 10) v = v & 8'b1111_0011;
    return 8'(v);
  endfunction

  function automatic logic [3:0] exp_cdr();
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = (mdl[c][10] & 8'h0C) == 8'h0C;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic model_reload(input int c);
    for (int a = 0; a < 16; a++) mdl[c][a] = exp_default(a);
  endtask

  task automatic do_write(input int c, input int a, input logic [7:0] d, input string req);
    @(negedge clk);
    bus_we = 1'b1; bus_ch = 2'(c); bus_addr = 4'(a); bus_wdata = d;
    @(posedge clk);
    #1;
    if (a == 0 && d[2]) begin model_reload(c); exp_pulse = 4'(1 << c); end
    else begin mdl[c][a] = d; exp_pulse = '0; end
    bus_we = 1'b0;
    chk(restore_pulse == exp_pulse, req, restore_pulse, exp_pulse);
    chk(cdr_rst == exp_cdr(), req, cdr_rst, exp_cdr());
  endtask

  task automatic idle_cycle();
    @(posedge clk);
    #1;
    exp_pulse = '0;
    chk(restore_pulse == 4'h0, "R4 pulse width", restore_pulse, 0);
  endtask

  task automatic check_reg(input int c, input int a, input string req);
    @(negedge clk);
    bus_we = 1'b0; bus_ch = 2'(c); bus_addr = 4'(a);
    #2;
    chk(bus_rdata == mdl[c][a], req, bus_rdata, mdl[c][a]);
  endtask

  task automatic sweep(input string req);
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 16; a++) check_reg(c, a, req);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    for (int c = 0; c < 4; c++) model_reload(c);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    chk(restore_pulse == 0, "R1 pulse at reset", restore_pulse, 0);
    chk(cdr_rst == 0, "R1 cdr at reset", cdr_rst, 0);
    sweep("R1 defaults");

    // R6: force alone, enable alone, then R5 both, then release.
    do_write(1, 10, 8'h04, "R6 force only");
    do_write(1, 10, 8'h08, "R6 enable only");
    do_write(1, 5, 8'h3C, "R2 plain write");
    do_write(1, 10, 8'h0C, "R5 both in one write");
    chk(cdr_rst == 4'b0010, "R5 channel one only", cdr_rst, 4'b0010);
    sweep("R7 regs untouched by cdr reset");
    do_write(1, 10, 8'h08, "R6 clear force releases");
    chk(cdr_rst == 4'b0000, "R6 released", cdr_rst, 0);
    do_write(1, 10, 8'hFF, "R5 set again");
    check_reg(1, 9, "R9 read live");

    // R8 and R3: full restore during CDR reset.
    do_write(2, 3, 8'h11, "R2 other channel");
    do_write(1, 0, 8'hFF, "R3 full restore");
    chk(cdr_rst[1] == 1'b0, "R8 override cleared", cdr_rst, 0);
    check_reg(1, 0, "R3 request bit reads zero");
    chk(bus_rdata[2] == 1'b0, "R3 self clear", bus_rdata, 0);
    idle_cycle();
    sweep("R3 channel reloaded, R2 others kept");

    // Random mix.
    for (int n = 0; n < 600; n++) begin
      int c, a, sel;
      logic [7:0] d;
      c = $urandom % 4;
      sel = $urandom % 8;
      a = (sel == 0) ? 0 : (sel < 3) ? 10 : ($urandom % 16);
      d = 8'($urandom);
      do_write(c, a, d, "R2 random write");
      check_reg($urandom % 4, $urandom % 16, "R9 random read");
      if (n % 75 == 74) sweep("R2 periodic sweep");
    end
    sweep("R2 final sweep");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule